// File: doc/BRIEF.md
# Retire-Gated I/O Load Replay Queue

This block sits between load issue and the downstream miss/request path and holds loads aimed at the I/O half of the physical address space. Such loads may have side effects, so none of them may go out while it is still speculative. Loads arrive in program order, each with a 44-bit physical address and a tag. Only loads whose address has bit 43 set are kept. A held load waits until the retire port names its tag.

Retired loads leave through a registered valid/ready request port. They leave strictly in the order they arrived, at most one per cycle. A younger load that has retired never overtakes an older one that has not. A flush input throws away the speculative part of the queue. Loads that have already retired and sit at the front of the queue survive the flush and still go out.

Top module: `ioq_replay_queue`

## Requirements
- R1: A presented load is enqueued only when `in_valid`, `in_ready` and address bit 43 are all 1. A load with bit 43 at 0 is dropped and never appears on the request port, even if its tag is later retired.
- R2: The queue holds up to DEPTH (8) loads, not counting the output register. `in_ready` is 0 exactly when DEPTH loads are held.
- R3: A retire pulse (`ret_valid` with `ret_tag`) marks every held load with that tag as retired. A load that is not retired never appears on the request port.
- R4: Loads leave the request port in the order they were enqueued. A retired load waits behind every older unretired load.
- R5: At most one load is handed over per cycle. A retire edge sets the flag, and the next edge moves the retired head into the empty output register, so `out_valid` rises two edges after the retire is sampled.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_tag` hold their values.
- R7: On `flush`, the queue keeps only the unbroken run of retired loads starting at the oldest. A retire sampled in the same cycle counts toward that run. Every other held load is discarded, and a load offered in the flush cycle is not enqueued. The output register is unaffected.
- R8: After synchronous reset the queue is empty, `out_valid` is 0 and `in_ready` is 1.
- R9: A retire whose tag matches no held load changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A load is offered |
| in_ready | output | 1 | Queue has room |
| in_addr | input | 44 | Physical address of the offered load |
| in_tag | input | TAG_W | Tag of the offered load |
| ret_valid | input | 1 | Retire pulse |
| ret_tag | input | TAG_W | Tag of the retiring load |
| flush | input | 1 | Discard speculative loads |
| out_valid | output | 1 | Request port holds a retired load |
| out_ready | input | 1 | Downstream accepts the request |
| out_addr | output | 44 | Address of the issued load |
| out_tag | output | TAG_W | Tag of the issued load |

## Verification
Flush and retirement can fall in the same cycle. A retire sampled with a flush decides whether that load survives, so the bench retires the third-oldest load in the very cycle it flushes a full queue, and it offers a new load in that same cycle. It then judges the outcome by draining the queue: exactly the three oldest loads must come out, in order, and nothing else. Random runs raise flush, retire, enqueue and handshake together many times. Every handover is compared with a model that applies the retire before the flush.

// File: rtl/ioq_pkg.sv
package ioq_pkg;
  localparam int unsigned PA_W   = 44;
  localparam int unsigned IO_BIT = PA_W - 1;
endpackage

// File: rtl/ioq_tag_cam.sv
module ioq_tag_cam #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 5,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic [DEPTH-1:0] eq
);
  logic [TAG_W-1:0] tags_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) tags_q[widx] <= wtag;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = (tags_q[i] == cmp_tag);
  end
endmodule

// File: rtl/ioq_addr_ram.sv
module ioq_addr_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 49,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [PTR_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ioq_out_reg.sv
module ioq_out_reg #(
  parameter int unsigned PA_W  = 44,
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PA_W-1:0]  ld_addr,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic             out_ready,
  output logic             free,
  output logic             out_valid,
  output logic [PA_W-1:0]  out_addr,
  output logic [TAG_W-1:0] out_tag
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_addr <= ld_addr;
      out_tag  <= ld_tag;
    end
  end

  assign free      = ~valid_q | out_ready;
  assign out_valid = valid_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_tag)));
endmodule

// File: rtl/ioq_replay_queue.sv
module ioq_replay_queue
  import ioq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PA_W-1:0]  in_addr,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  input  logic             flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  out_addr,
  output logic [TAG_W-1:0] out_tag
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;
  localparam int unsigned ENT_W = PA_W + TAG_W;

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q, cnt_n, keep_cnt;
  logic [DEPTH-1:0] occ_q, retd_q, retd_n, hit, tag_eq, keep_mask;
  logic             push, pop, stage_free;
  logic [ENT_W-1:0] head_ent;

  assign in_ready = (cnt_q != CNT_W'(DEPTH));
  assign push     = in_valid & in_ready & in_addr[IO_BIT] & ~flush;
  assign hit      = tag_eq & occ_q & {DEPTH{ret_valid}};
  assign retd_n   = retd_q | hit;
  assign pop      = occ_q[head_q] & retd_q[head_q] & stage_free;

  ioq_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cam (
    .clk(clk), .we(push), .widx(tail_q), .wtag(in_tag),
    .cmp_tag(ret_tag), .eq(tag_eq)
  );

  ioq_addr_ram #(.DEPTH(DEPTH), .W(ENT_W)) u_ram (
    .clk(clk), .we(push), .widx(tail_q), .wdata({in_tag, in_addr}),
    .ridx(head_q), .rdata(head_ent)
  );

  ioq_out_reg #(.PA_W(PA_W), .TAG_W(TAG_W)) u_out (
    .clk(clk), .rst(rst), .load(pop),
    .ld_addr(head_ent[PA_W-1:0]), .ld_tag(head_ent[ENT_W-1:PA_W]),
    .out_ready(out_ready), .free(stage_free),
    .out_valid(out_valid), .out_addr(out_addr), .out_tag(out_tag)
  );

  // Retired run starting at the head, used when flushing
  always_comb begin
    logic             still;
    logic [PTR_W-1:0] idx;
    still     = 1'b1;
    keep_mask = '0;
    keep_cnt  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q + PTR_W'(k);
      if (still && occ_q[idx] && retd_n[idx]) begin
        keep_mask[idx] = 1'b1;
        keep_cnt       = keep_cnt + CNT_W'(1);
      end else begin
        still = 1'b0;
      end
    end
  end

  always_comb begin
    cnt_n = flush ? keep_cnt : cnt_q + CNT_W'(push);
    cnt_n = cnt_n - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      occ_q  <= '0;
      retd_q <= '0;
    end else begin
      retd_q <= retd_n;
      cnt_q  <= cnt_n;
      if (flush) begin
        occ_q  <= keep_mask;
        tail_q <= head_q + keep_cnt[PTR_W-1:0];
      end else if (push) begin
        occ_q[tail_q]  <= 1'b1;
        retd_q[tail_q] <= 1'b0;
        tail_q         <= tail_q + PTR_W'(1);
      end
      if (pop) begin
        occ_q[head_q]  <= 1'b0;
        retd_q[head_q] <= 1'b0;
        head_q         <= head_q + PTR_W'(1);
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  p_cnt_occ_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(occ_q) == int'(cnt_q));
  p_nonio_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_addr[IO_BIT]) |=> (cnt_q <= $past(cnt_q)));
  p_flush_clean_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((occ_q & ~retd_q) == '0));
  p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !flush && !pop) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: tb/ioq_replay_queue_test.sv
module ioq_replay_queue_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int TAG_W = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_ready, ret_valid = 0, flush = 0, out_valid, out_ready = 0;
  logic [43:0] in_addr = '0, out_addr;
  logic [TAG_W-1:0] in_tag = '0, ret_tag = '0, out_tag;

  always #(CLK_P/2) clk = ~clk;

  ioq_replay_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_tag(in_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_tag(out_tag)
  );

  int errors = 0, checks = 0, xfers = 0;
  logic [43:0] m_addr [16];
  logic [TAG_W-1:0] m_tag [16];
  bit m_ret [16];
  int m_n = 0;
  logic [TAG_W-1:0] next_tag = '0;
  bit hold_prev = 0;
  logic [43:0] prev_addr;
  logic [TAG_W-1:0] prev_tag;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready();
    return (m_n - (out_valid ? 1 : 0)) < DEPTH;
  endfunction

  task automatic cycle(bit iv, logic [43:0] ia, logic [TAG_W-1:0] it,
                       bit rv, logic [TAG_W-1:0] rt, bit fl, bit ordy);
    bit xf, pu;
    int k;
    @(negedge clk);
    chk(in_ready == exp_ready(), "R2", "in_ready", in_ready, exp_ready());
    if (hold_prev)
      chk(out_valid && out_addr == prev_addr && out_tag == prev_tag, "R6",
          "held request", out_addr, prev_addr);
    in_valid = iv; in_addr = ia; in_tag = it;
    ret_valid = rv; ret_tag = rt; flush = fl; out_ready = ordy;
    xf = out_valid && ordy;
    pu = iv && in_ready && ia[43] && !fl;
    if (xf) begin
      xfers++;
      chk(m_n > 0 && out_addr == m_addr[0] && out_tag == m_tag[0], "R4",
          "issue order", out_addr, m_addr[0]);
      chk(m_n > 0 && m_ret[0], "R3", "issued load retired", m_ret[0], 1);
      for (int i = 1; i < 16; i++) begin
        m_addr[i-1] = m_addr[i]; m_tag[i-1] = m_tag[i]; m_ret[i-1] = m_ret[i];
      end
      if (m_n > 0) m_n--;
    end
    hold_prev = out_valid && !ordy;
    prev_addr = out_addr; prev_tag = out_tag;
    if (rv) for (int i = 0; i < m_n; i++) if (m_tag[i] == rt) m_ret[i] = 1;
    if (fl) begin
      k = 0;
      while (k < m_n && m_ret[k]) k++;
      m_n = k;
    end
    if (pu) begin
      m_addr[m_n] = ia; m_tag[m_n] = it; m_ret[m_n] = 0; m_n++;
      next_tag = next_tag + 1'b1;
    end
  endtask

  function automatic logic [43:0] rnd_io();
    return {1'b1, 11'($urandom), 32'($urandom)};
  endfunction

  task automatic idle(bit ordy, int n);
    for (int i = 0; i < n; i++) cycle(0, '0, '0, 0, '0, 0, ordy);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [43:0] a;
    int x0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R8 reset state
    chk(in_ready == 1 && out_valid == 0, "R8", "reset state", {in_ready, out_valid}, 2'b10);

    // R1 non-I/O load dropped even after its tag is retired
    cycle(1, 44'h0_1234_5678, 5'd20, 0, '0, 0, 1);
    cycle(0, '0, '0, 1, 5'd20, 0, 1);
    idle(1, 3);
    chk(out_valid == 0 && m_n == 0, "R1", "non-I/O ignored", out_valid, 0);

    // R2 fill to capacity without retiring
    for (int i = 0; i < DEPTH; i++) cycle(1, rnd_io(), next_tag, 0, '0, 0, 0);
    idle(0, 1);
    chk(in_ready == 0, "R2", "full blocks input", in_ready, 0);
    // R9 unknown tag changes nothing
    cycle(0, '0, '0, 1, next_tag + 5'd16, 0, 0);
    idle(0, 3);
    chk(out_valid == 0, "R9", "bogus retire", out_valid, 0);

    // R4 younger retired waits behind older unretired
    cycle(0, '0, '0, 1, m_tag[1], 0, 0);
    idle(0, 4);
    chk(out_valid == 0, "R4", "no bypass", out_valid, 0);
    // R5 retire head: out_valid rises two edges later
    cycle(0, '0, '0, 1, m_tag[0], 0, 0);
    cycle(0, '0, '0, 0, '0, 0, 0);
    chk(out_valid == 0, "R5", "one edge after retire", out_valid, 0);
    idle(0, 1);
    chk(out_valid == 1 && out_addr == m_addr[0], "R5", "two edges after retire", out_valid, 1);

    // R7 flush with same-cycle retire of third load and an offered load
    x0 = xfers;
    a = rnd_io();
    cycle(1, a, next_tag, 1, m_tag[2], 1, 0);
    idle(0, 1);
    chk(m_n == 3, "R7", "model keeps three", m_n, 3);
    idle(1, 8);
    chk(xfers - x0 == 3, "R7", "survivors issued", xfers - x0, 3);
    chk(out_valid == 0 && in_ready == 1, "R7", "drained after flush", out_valid, 0);

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      bit iv, rv, fl, ordy, io;
      logic [TAG_W-1:0] rt;
      int pick;
      iv = ($urandom % 3) != 0;
      io = ($urandom % 8) != 0;
      rv = ($urandom % 2) == 0;
      fl = ($urandom % 40) == 0;
      ordy = ($urandom % 4) != 0;
      rt = next_tag + 5'd16;
      if (rv && m_n > 0 && ($urandom % 8) != 0) begin
        pick = 0;
        while (pick < m_n && m_ret[pick]) pick++;
        if (($urandom % 5) == 0) pick = $urandom % m_n;
        if (pick < m_n) rt = m_tag[pick];
      end
      a = rnd_io();
      if (!io) a[43] = 1'b0;
      cycle(iv, a, io ? next_tag : next_tag + 5'd16, rv, rt, fl, ordy);
    end

    // Drain: retire oldest unretired each cycle
    for (int c = 0; c < 60; c++) begin
      int pick;
      pick = 0;
      while (pick < m_n && m_ret[pick]) pick++;
      if (pick < m_n) cycle(0, '0, '0, 1, m_tag[pick], 0, 1);
      else cycle(0, '0, '0, 0, '0, 0, 1);
    end
    chk(m_n == 0 && out_valid == 0, "R4", "all retired loads issued", m_n, 0);
    chk(in_ready == 1, "R2", "empty after drain", in_ready, 1);
    finish_run();
  end
endmodule